// File: doc/BRIEF.md
# Character-Serial Instruction Fetch and Decode

This block reads one instruction from a character-addressed store, one character at a time. Each stored character has six data bits and a parity bit. A pulse on `start` carries the address of the first character. The block then issues five reads at consecutive addresses. It checks the parity of every character that comes back and shifts the six data bits into a 30-bit instruction word. The first character read ends up in the most significant position.

Once the fifth character is in, the word is split into its fields: a 5-bit operation code, a 3-bit index selector, one reserved bit, a 15-bit operand address and a 6-bit detail field. The effective address is the operand address plus the content of the selected index register. Selector zero means no indexing. Seven 15-bit index registers sit inside the block and are loaded through a write port. A one-cycle `done` pulse presents the result.

Read requests use a valid/ready handshake. The block raises `rd_valid` with `rd_addr` and holds both until `rd_ready` is seen. It then waits for `rsp_valid` with the character before it asks for the next one. The response side has no back-pressure: the block only asks for a character when it can take it, so `rsp_valid` is always accepted.

Top module: `char_fetch_decode`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `done`, `illegal` and `parity_err` are 0, and every decoded output and `eff_addr` is 0.
- R2: An accepted start issues exactly five reads at `start_addr`, `start_addr+1`, and so on, wrapping modulo 2^15. A new request is raised only after the response to the previous one.
- R3: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` holds its value.
- R4: The word is assembled with the first character in bits 29:24. The fields are opcode = bits 29:25, index selector = bits 24:22, reserved = bit 21, operand address = bits 20:6 and detail = bits 5:0.
- R5: `eff_addr` equals the operand address plus the selected index register, modulo 2^15. Selector 0 adds nothing.
- R6: A write with `ix_we` high and `ix_sel` from 1 to 7 loads `ix_wdata` into that register. A write with `ix_sel` = 0 has no effect, so selector 0 still adds zero.
- R7: Each character is valid when its 7 bits (parity in bit 6, data in bits 5:0) hold an odd number of ones. On a mismatch the block sets `parity_err`, abandons the fetch with no further reads, drops `busy` and never pulses `done` for that fetch.
- R8: If the reserved bit of a completed word is 1, `illegal` is set in the same cycle as `done`. The fields are still decoded.
- R9: `done` is high for exactly one cycle. The decoded outputs and `eff_addr` stay unchanged afterwards until the next accepted start.
- R10: A `start` pulse while `busy` is high is ignored. The running fetch keeps its addresses.
- R11: An accepted start clears `parity_err` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch (taken only when idle) |
| start_addr | input | 15 | Address of the first character |
| busy | output | 1 | Fetch in progress |
| rd_valid | output | 1 | Character read request |
| rd_ready | input | 1 | Store accepts the request |
| rd_addr | output | 15 | Character address of the request |
| rsp_valid | input | 1 | Returned character is present |
| rsp_data | input | 7 | Parity bit 6, data bits 5:0 |
| ix_we | input | 1 | Index register write enable |
| ix_sel | input | 3 | Index register to write (0 ignored) |
| ix_wdata | input | 15 | Index register write value |
| done | output | 1 | One-cycle pulse: decode complete |
| opcode | output | 5 | Operation code |
| xsel | output | 3 | Index selector |
| rsvd_bit | output | 1 | Reserved bit as fetched |
| addr_field | output | 15 | Operand address field |
| detail | output | 6 | Detail field |
| eff_addr | output | 15 | Indexed effective address |
| illegal | output | 1 | Reserved bit was set |
| parity_err | output | 1 | Parity failure aborted the last fetch |

## Verification
The assertions assume that the store answers each accepted request with exactly one `rsp_valid` pulse, and never sends a response with no request outstanding. The stimulus meets this with a bench responder that holds at most one pending request. It returns the character after a programmable latency, and in some runs it toggles `rd_ready` to apply back-pressure. Index registers are written only while the block is idle. The bench raises `start` while busy only in the test aimed at that case, so the effective address is always formed from settled register contents.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int CHAR_W  = 6;
  localparam int NCHAR   = 5;
  localparam int ADDR_W  = 15;
  localparam int OPC_W   = 5;
  localparam int XSEL_W  = 3;
  localparam int DET_W   = 6;
  localparam int WORD_W  = CHAR_W * NCHAR;
  localparam int CNT_W   = $clog2(NCHAR);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DEC  = 2'd3
  } fetch_st_t;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [XSEL_W-1:0] xs;
    logic              rsv;
    logic [ADDR_W-1:0] af;
    logic [DET_W-1:0]  det;
  } instr_t;
endpackage

// File: rtl/cfd_parity_chk.sv
module cfd_parity_chk #(
  parameter int DW = 6
) (
  input  logic [DW:0] ch,
  output logic        ok
);
  // odd parity over data plus parity bit
  assign ok = ^ch;
endmodule

// File: rtl/cfd_index_file.sv
module cfd_index_file #(
  parameter int AW = 15,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [AW-1:0] wdata,
  input  logic [SW-1:0] rsel,
  output logic [AW-1:0] rdata
);
  localparam int NREG = (1 << SW) - 1;

  logic [NREG:0][AW-1:0] bank;

  assign bank[0] = '0;  // selector zero: no index modification

  for (genvar k = 1; k <= NREG; k++) begin : g_reg
    logic [AW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (we && (wsel == SW'(k)))
        q <= wdata;
    end
    assign bank[k] = q;
  end

  assign rdata = bank[rsel];

  assert_zero_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == '0) |-> (rdata == '0));
endmodule

// File: rtl/cfd_fetch_seq.sv
module cfd_fetch_seq
  import cfd_pkg::*;
#(
  parameter int CW = CHAR_W,
  parameter int NC = NCHAR,
  parameter int AW = ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [AW-1:0]      start_addr,
  output logic               start_acc,
  output logic               busy,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [AW-1:0]      rd_addr,
  input  logic               rsp_valid,
  input  logic [CW:0]        rsp_data,
  output logic               par_fail,
  output logic               dec_go,
  output logic [CW*NC-1:0]   word
);
  localparam int WW = CW * NC;
  localparam int CNTW = (NC > 1) ? $clog2(NC) : 1;

  fetch_st_t      st;
  logic [AW-1:0]  ptr;
  logic [CNTW-1:0] cnt;
  logic           pok;
  logic           take;

  cfd_parity_chk #(.DW(CW)) u_par (
    .ch (rsp_data),
    .ok (pok)
  );

  assign busy      = (st != ST_IDLE);
  assign start_acc = start && (st == ST_IDLE);
  assign rd_valid  = (st == ST_REQ);
  assign rd_addr   = ptr;
  assign take      = (st == ST_WAIT) && rsp_valid;
  assign par_fail  = take && !pok;
  assign dec_go    = (st == ST_DEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ptr  <= '0;
      cnt  <= '0;
      word <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st   <= ST_REQ;
            ptr  <= start_addr;
            cnt  <= '0;
            word <= '0;
          end
        end
        ST_REQ: begin
          if (rd_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (!pok) begin
              st <= ST_IDLE;
            end else begin
              word <= {word[WW-CW-1:0], rsp_data[CW-1:0]};
              ptr  <= ptr + 1'b1;
              if (cnt == CNTW'(NC - 1)) begin
                st <= ST_DEC;
              end else begin
                cnt <= cnt + 1'b1;
                st  <= ST_REQ;
              end
            end
          end
        end
        ST_DEC: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_valid);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pok && (cnt != CNTW'(NC - 1))) |=> (rd_valid && (rd_addr == $past(rd_addr) + 1'b1)));

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    par_fail |=> (!busy && !rd_valid));
endmodule

// File: rtl/char_fetch_decode.sv
module char_fetch_decode
  import cfd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  output logic                busy,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rsp_valid,
  input  logic [CHAR_W:0]     rsp_data,
  input  logic                ix_we,
  input  logic [XSEL_W-1:0]   ix_sel,
  input  logic [ADDR_W-1:0]   ix_wdata,
  output logic                done,
  output logic [OPC_W-1:0]    opcode,
  output logic [XSEL_W-1:0]   xsel,
  output logic                rsvd_bit,
  output logic [ADDR_W-1:0]   addr_field,
  output logic [DET_W-1:0]    detail,
  output logic [ADDR_W-1:0]   eff_addr,
  output logic                illegal,
  output logic                parity_err
);
  logic              start_acc;
  logic              par_fail;
  logic              dec_go;
  logic [WORD_W-1:0] word;
  instr_t            fld;
  logic [ADDR_W-1:0] ix_val;

  cfd_fetch_seq #(.CW(CHAR_W), .NC(NCHAR), .AW(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .start_acc  (start_acc),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .par_fail   (par_fail),
    .dec_go     (dec_go),
    .word       (word)
  );

  assign fld = instr_t'(word);

  cfd_index_file #(.AW(ADDR_W), .SW(XSEL_W)) u_ix (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ix_we),
    .wsel  (ix_sel),
    .wdata (ix_wdata),
    .rsel  (fld.xs),
    .rdata (ix_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      opcode     <= '0;
      xsel       <= '0;
      rsvd_bit   <= 1'b0;
      addr_field <= '0;
      detail     <= '0;
      eff_addr   <= '0;
      illegal    <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      done <= dec_go;
      if (start_acc) begin
        illegal    <= 1'b0;
        parity_err <= 1'b0;
      end
      if (par_fail) parity_err <= 1'b1;
      if (dec_go) begin
        opcode     <= fld.opc;
        xsel       <= fld.xs;
        rsvd_bit   <= fld.rsv;
        addr_field <= fld.af;
        detail     <= fld.det;
        eff_addr   <= fld.af + ix_val;
        illegal    <= fld.rsv;
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fields_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(eff_addr) && $stable(opcode) && $stable(addr_field) && $stable(detail)));

  assert_no_done_on_perr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> !done);

  assert_done_after_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/char_fetch_decode_tb.sv
module char_fetch_decode_tb;
  localparam time TCLK = 10ns;
  localparam int  NV = 5;
  // {start_addr, opcode, xsel, addr_field, detail}
  localparam logic [43:0] VEC [NV] = '{
    {15'h0010, 5'h1F, 3'd0, 15'h0100, 6'h2A},
    {15'h0040, 5'h03, 3'd1, 15'h1234, 6'h3F},
    {15'h00FB, 5'h10, 3'd7, 15'h7FFE, 6'h00},
    {15'h7FFE, 5'h0A, 3'd3, 15'h0005, 6'h15},
    {15'h0080, 5'h15, 3'd5, 15'h4000, 6'h01}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [14:0] start_addr = '0;
  logic busy, rd_valid, rd_addr_unused;
  logic rd_ready = 1;
  logic [14:0] rd_addr;
  logic rsp_valid = 0;
  logic [6:0] rsp_data = '0;
  logic ix_we = 0;
  logic [2:0] ix_sel = '0;
  logic [14:0] ix_wdata = '0;
  logic done, rsvd_bit, illegal, parity_err;
  logic [4:0] opcode;
  logic [2:0] xsel;
  logic [14:0] addr_field, eff_addr;
  logic [5:0] detail;

  char_fetch_decode u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .busy(busy),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ix_we(ix_we), .ix_sel(ix_sel), .ix_wdata(ix_wdata),
    .done(done), .opcode(opcode), .xsel(xsel), .rsvd_bit(rsvd_bit),
    .addr_field(addr_field), .detail(detail), .eff_addr(eff_addr),
    .illegal(illegal), .parity_err(parity_err)
  );
  assign rd_addr_unused = 1'b0;

  always #(TCLK/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [6:0] mem [256];
  logic [14:0] ixm [8];
  logic [14:0] log_a [16];
  int log_n = 0, overlap = 0, lat = 1;
  bit stall = 0, pending = 0, finished = 0;
  logic [14:0] pa;
  int lat_cnt = 0;
  int done_cnt;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] mkc(input logic [5:0] d);
    return {~^d, d};
  endfunction

  function automatic logic [29:0] mkw(input logic [4:0] o, input logic [2:0] x, input logic r,
                                      input logic [14:0] a, input logic [5:0] d);
    return {o, x, r, a, d};
  endfunction

  task automatic load(input logic [14:0] a, input logic [29:0] w, input int bad);
    for (int i = 0; i < 5; i++) begin
      logic [14:0] p = a + 15'(i);
      mem[p[7:0]] = mkc(w[29-6*i -: 6]);
      if (i == bad) mem[p[7:0]][6] = ~mem[p[7:0]][6];
    end
  endtask

  // store responder: one request at a time
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (pending && rd_valid) overlap++;
      if (pending) begin
        if (lat_cnt <= 1) begin
          rsp_valid = 1;
          rsp_data = mem[pa[7:0]];
          pending = 0;
        end else lat_cnt--;
      end
      rd_ready = stall ? ~rd_ready : 1'b1;
      if (!pending && rd_valid && rd_ready && rst_n) begin
        pending = 1;
        pa = rd_addr;
        lat_cnt = lat;
        if (log_n < 16) log_a[log_n] = rd_addr;
        log_n++;
      end
    end
  end

  task automatic ix_write(input logic [2:0] s, input logic [14:0] v);
    ix_we = 1; ix_sel = s; ix_wdata = v;
    @(negedge clk);
    ix_we = 0;
    if (s != 0) ixm[s] = v;
  endtask

  task automatic fetch(input logic [14:0] a);
    log_n = 0; overlap = 0; done_cnt = 0;
    start = 1; start_addr = a;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 200; i++) begin
      if (done || parity_err) break;
      @(negedge clk);
    end
  endtask

  task automatic check_fetch(input string tag, input logic [14:0] a, input logic [29:0] w);
    logic [14:0] e;
    e = (w[20:6] + ixm[w[24:22]]) & 15'h7fff;
    chk(done === 1'b1, {tag, " R9 done"}, 32'(done), 1);
    chk(opcode === w[29:25], {tag, " R4 opcode"}, 32'(opcode), 32'(w[29:25]));
    chk(xsel === w[24:22], {tag, " R4 xsel"}, 32'(xsel), 32'(w[24:22]));
    chk(addr_field === w[20:6], {tag, " R4 addr"}, 32'(addr_field), 32'(w[20:6]));
    chk(detail === w[5:0], {tag, " R4 detail"}, 32'(detail), 32'(w[5:0]));
    chk(rsvd_bit === w[21] && illegal === w[21], {tag, " R8 illegal"}, 32'(illegal), 32'(w[21]));
    chk(eff_addr === e, {tag, " R5 eff"}, 32'(eff_addr), 32'(e));
    chk(log_n == 5 && overlap == 0, {tag, " R2 count"}, 32'(log_n), 5);
    for (int i = 0; i < 5; i++)
      chk(log_a[i] === a + 15'(i), {tag, " R2 addr"}, 32'(log_a[i]), 32'(a + 15'(i)));
    @(negedge clk);
    chk(done === 1'b0, {tag, " R9 pulse"}, 32'(done), 0);
    repeat (3) @(negedge clk);
    chk(eff_addr === e && opcode === w[29:25], {tag, " R9 hold"}, 32'(eff_addr), 32'(e));
  endtask

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) ixm[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = 7'h40;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !rd_valid && !done && !illegal && !parity_err, "R1 ctrl", 32'({busy, rd_valid, done}), 0);
    chk(eff_addr === 0 && opcode === 0 && addr_field === 0 && detail === 0, "R1 fields", 32'(eff_addr), 0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 1; k < 8; k++) ix_write(3'(k), 15'(k * 32'h1111));

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [29:0] w;
      w = mkw(VEC[v][28:24], VEC[v][23:21], 1'b0, VEC[v][20:6], VEC[v][5:0]);
      lat = 1 + (v % 3);
      stall = (v % 2) == 1;
      load(VEC[v][43:29], w, -1);
      fetch(VEC[v][43:29]);
      check_fetch($sformatf("vec%0d", v), VEC[v][43:29], w);
    end
    stall = 0; lat = 1;

    // R8 reserved bit set
    begin
      logic [29:0] w = mkw(5'h07, 3'd2, 1'b1, 15'h0300, 6'h11);
      load(15'h0020, w, -1);
      fetch(15'h0020);
      check_fetch("rsvd", 15'h0020, w);
    end

    // R7 parity failure on third character
    begin
      logic [29:0] w = mkw(5'h01, 3'd1, 1'b0, 15'h0001, 6'h01);
      load(15'h0030, w, 2);
      fetch(15'h0030);
      chk(parity_err === 1'b1, "R7 flag", 32'(parity_err), 1);
      for (int i = 0; i < 10; i++) begin
        if (done) done_cnt++;
        @(negedge clk);
      end
      chk(done_cnt == 0, "R7 no done", 32'(done_cnt), 0);
      chk(!busy && log_n == 3, "R7 abort reads", 32'(log_n), 3);
      // R11 next good start clears the flag
      load(15'h0030, w, -1);
      fetch(15'h0030);
      chk(parity_err === 1'b0, "R11 clear perr", 32'(parity_err), 0);
      check_fetch("after_perr", 15'h0030, w);
    end

    // R11 illegal cleared by next start
    begin
      logic [29:0] w = mkw(5'h02, 3'd0, 1'b0, 15'h0044, 6'h02);
      load(15'h0050, w, -1);
      fetch(15'h0050);
      chk(illegal === 1'b0, "R11 clear illegal", 32'(illegal), 0);
    end

    // R6 write to selector zero ignored; selector 3 overwritten
    begin
      logic [29:0] w0 = mkw(5'h04, 3'd0, 1'b0, 15'h0200, 6'h05);
      logic [29:0] w3 = mkw(5'h04, 3'd3, 1'b0, 15'h0200, 6'h05);
      ix_write(3'd0, 15'h1234);
      load(15'h0060, w0, -1);
      fetch(15'h0060);
      chk(eff_addr === 15'h0200, "R6 sel0 ignored", 32'(eff_addr), 32'h200);
      ix_write(3'd3, 15'h0001);
      load(15'h0060, w3, -1);
      fetch(15'h0060);
      chk(eff_addr === 15'h0201, "R6 sel3 write", 32'(eff_addr), 32'h201);
    end

    // R10 start while busy ignored
    begin
      logic [29:0] w = mkw(5'h19, 3'd4, 1'b0, 15'h0010, 6'h33);
      lat = 3;
      load(15'h0070, w, -1);
      log_n = 0; overlap = 0;
      start = 1; start_addr = 15'h0070;
      @(negedge clk);
      start = 0;
      repeat (4) @(negedge clk);
      start = 1; start_addr = 15'h00A0;
      @(negedge clk);
      start = 0;
      for (int i = 0; i < 200; i++) begin
        if (done) break;
        @(negedge clk);
      end
      check_fetch("R10 busy start", 15'h0070, w);
      lat = 1;
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule